// File: doc/BRIEF.md
# Serial Command Port with Event Interrupt

This block is the serial front end of a device controller. A host selects it with an active-low select line and supplies the serial clock. The host shifts command and configuration bytes in on MOSI, and status comes back on MISO. Both directions move least-significant bit first. The block samples MOSI on the rising serial clock edge and changes MISO on the falling edge. All serial inputs are brought into the system clock domain and edge-detected there, so the serial clock must run well below the system clock. A serial half period of at least four system clocks is safe.

The block also holds the interrupt for the storage engine. An overflow or end-of-message pulse from the engine sets a pending flag, and the active-low interrupt output stays low while any flag is pending. The flags are captured when a frame starts. That captured value is shifted out as the first byte on MISO, so a read-interrupt command gets the cause of the interrupt back while it is being sent. When a frame ends validly, only the captured flags are cleared. An event that arrives during the frame keeps the interrupt asserted.

A received frame leaves the block on a valid/ready stream as one data word plus a byte count. The word is held stable while valid is high and ready is low. A frame that completes while the previous word is still unaccepted is dropped, because the stream has no queue. That frame still clears the interrupt.

Top module: `spi_irq_slave`

## Requirements
- R1: While `ss_n` is low, MOSI is sampled on each rising `sclk` edge. Received bit k is placed at `rx_data[k]`, so the first bit is the LSB. Bits not received read as zero, and `rx_len` gives the frame length in whole bytes.
- R2: MISO changes only after a falling `sclk` edge and holds while `sclk` is high. The first bit is presented before the first rising edge. The first byte out is the flag byte, least-significant bit first: bit 0 is overflow, bit 1 is end-of-message, and bits 7:2 are zero. All later bytes are zero.
- R3: `miso_oe` is low whenever `ss_n` is high.
- R4: A pulse on `ovf_evt` or `eom_evt` sets its pending flag. `int_n` is low whenever any flag is pending.
- R5: A frame is complete when `ss_n` rises after a whole number of bytes, from 1 to `FRAME_BYTES`. Completion clears the flags that were pending at frame start, and it is the only way flags are cleared.
- R6: A frame that ends after a partial byte, or after more than `FRAME_BYTES` bytes, is discarded. It produces no `rx_valid` and leaves the flags untouched.
- R7: An event that arrives during a frame is not cleared by that frame's completion. It is returned as a flag by the next frame.
- R8: `rx_valid` stays high and `rx_data`/`rx_len` stay unchanged until `rx_ready` is high. A frame that completes while `rx_valid` is high is dropped.
- R9: After reset, `int_n` is high, `rx_valid` is low and no flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host (idles low) |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for MISO; low means high impedance |
| ovf_evt | input | 1 | Overflow event pulse from the storage engine |
| eom_evt | input | 1 | End-of-message event pulse from the storage engine |
| int_n | output | 1 | Active-low interrupt, open-drain style |
| rx_data | output | FRAME_BYTES*8 | Received frame, LSB first |
| rx_len | output | $clog2(FRAME_BYTES+1) | Received byte count |
| rx_valid | output | 1 | Received frame available |
| rx_ready | input | 1 | Consumer accepts the frame |

## Verification
Frames of one and two bytes with asymmetric bit patterns are sent. They show whether bits are assembled in LSB-first order and whether short frames are zero-filled. A five-bit frame is sent to check that a partial frame neither delivers data nor clears the interrupt. Overflow and end-of-message are each raised alone, and one event is injected halfway through a frame. The returned flag bytes then tell the two bit positions apart, and show whether the clear touches only the snapshot taken at frame start. Back-to-back frames with the stream stalled show whether the first word is held and the second dropped.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int FLAG_W   = 2;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_EOM = 1;
  typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rst_val,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  // One shift chain per bit.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{rst_val[b]}};
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags
  import spi_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ovf_evt,
  input  logic   eom_evt,
  input  logic   frame_start,
  input  logic   frame_done,
  output flags_t flags,
  output logic   int_n
);
  flags_t snap;
  flags_t evts;

  always_comb begin
    evts = '0;
    evts[FLAG_OVF] = ovf_evt;
    evts[FLAG_EOM] = eom_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      snap  <= '0;
    end else begin
      if (frame_start) snap <= flags;
      if (frame_done) flags <= (flags & ~snap) | evts;
      else            flags <= flags | evts;
    end
  end

  assign int_n = ~|flags;

  AST_EVENT_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt || eom_evt) |=> !int_n); // R4
  AST_CLEAR_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> $past(frame_done)); // R5
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_irq_pkg::*;
#(
  parameter int FRAME_BYTES = 2,
  localparam int FRAME_BITS = FRAME_BYTES * 8,
  localparam int LEN_W      = $clog2(FRAME_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_sclk,
  input  logic                  s_ss_n,
  input  logic                  s_mosi,
  input  flags_t                flags,
  output logic                  frame_start,
  output logic                  frame_done,
  output logic                  miso_q,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic [LEN_W-1:0]      rx_len,
  output logic                  rx_valid,
  input  logic                  rx_ready
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS);

  logic sclk_d, ss_d;
  logic sel, sclk_rise, sclk_fall, frame_end, whole;
  logic [CNT_W-1:0]      bit_cnt;
  logic [CNT_W-1:0]      byte_cnt;
  logic [FRAME_BITS-1:0] rx_sr;
  logic [FRAME_BITS-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      ss_d   <= 1'b1;
    end else begin
      sclk_d <= s_sclk;
      ss_d   <= s_ss_n;
    end
  end

  assign sel         = ~s_ss_n;
  assign sclk_rise   = sel & s_sclk & ~sclk_d;
  assign sclk_fall   = sel & ~s_sclk & sclk_d;
  assign frame_start = ~s_ss_n & ss_d;
  assign frame_end   = s_ss_n & ~ss_d;
  assign whole       = (bit_cnt[2:0] == 3'd0) && (bit_cnt != '0) && (bit_cnt <= CNT_MAX);
  assign frame_done  = frame_end & whole;
  assign byte_cnt    = bit_cnt >> 3;

  // Receive path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
    end else if (frame_start) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
    end else if (sclk_rise && bit_cnt != CNT_SAT) begin
      if (bit_cnt < CNT_MAX) rx_sr[bit_cnt[IDX_W-1:0]] <= s_mosi;
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // Transmit path: flag byte first, then zeros
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr  <= '0;
      miso_q <= 1'b0;
    end else if (frame_start) begin
      tx_sr  <= FRAME_BITS'(flags);
      miso_q <= flags[0];
    end else if (sclk_fall) begin
      tx_sr  <= tx_sr >> 1;
      miso_q <= tx_sr[1];
    end
  end

  // Output stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_len   <= '0;
    end else if (frame_done && !rx_valid) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_sr;
      rx_len   <= byte_cnt[LEN_W-1:0];
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_len))); // R8
  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !frame_start) |=> $stable(miso_q)); // R2
  AST_DONE_CLOSES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !sel); // R5
endmodule

// File: rtl/spi_irq_slave.sv
module spi_irq_slave
  import spi_irq_pkg::*;
#(
  parameter int FRAME_BYTES = 2,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_BITS = FRAME_BYTES * 8,
  localparam int LEN_W      = $clog2(FRAME_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  ss_n,
  input  logic                  mosi,
  output logic                  miso,
  output logic                  miso_oe,
  input  logic                  ovf_evt,
  input  logic                  eom_evt,
  output logic                  int_n,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic [LEN_W-1:0]      rx_len,
  output logic                  rx_valid,
  input  logic                  rx_ready
);
  logic [2:0] s_in;
  flags_t     flags;
  logic       frame_start, frame_done;

  spi_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (3'b010),
    .din     ({mosi, ss_n, sclk}),
    .dout    (s_in)
  );

  spi_irq_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovf_evt     (ovf_evt),
    .eom_evt     (eom_evt),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .flags       (flags),
    .int_n       (int_n)
  );

  spi_frame_shifter #(.FRAME_BYTES(FRAME_BYTES)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_sclk      (s_in[0]),
    .s_ss_n      (s_in[1]),
    .s_mosi      (s_in[2]),
    .flags       (flags),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .miso_q      (miso),
    .rx_data     (rx_data),
    .rx_len      (rx_len),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready)
  );

  assign miso_oe = ~ss_n;

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n)) |-> !miso_oe); // R3
endmodule

// File: tb/sim_spi_irq_slave.sv
`timescale 1ns/1ps
module sim_spi_irq_slave;
  localparam int HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic ovf_evt = 1'b0, eom_evt = 1'b0, rx_ready = 1'b0;
  logic miso, miso_oe, int_n, rx_valid;
  logic [15:0] rx_data;
  logic [1:0]  rx_len;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  spi_irq_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .ovf_evt(ovf_evt), .eom_evt(eom_evt),
    .int_n(int_n), .rx_data(rx_data), .rx_len(rx_len), .rx_valid(rx_valid),
    .rx_ready(rx_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_evt(input bit ovf);
    @(negedge clk);
    if (ovf) ovf_evt = 1'b1; else eom_evt = 1'b1;
    @(negedge clk);
    ovf_evt = 1'b0; eom_evt = 1'b0;
  endtask

  // evt_at >= 0 injects an eom pulse at that bit
  task automatic xfer(input int nbits, input logic [15:0] din, input int evt_at,
                      output logic [15:0] dout, output bit stable);
    dout = '0; stable = 1'b1;
    ss_n = 1'b0;
    wclk(10);
    for (int i = 0; i < nbits; i++) begin
      mosi = din[i];
      if (i == evt_at) pulse_evt(1'b0);
      wclk(HALF);
      if (i < 16) dout[i] = miso;
      sclk = 1'b1;
      wclk(HALF);
      if (i < 16 && miso !== dout[i]) stable = 1'b0;
      sclk = 1'b0;
    end
    wclk(HALF);
    ss_n = 1'b1;
    wclk(10);
  endtask

  task automatic accept;
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    wclk(2);
  endtask

  task automatic t_reset;
    check(int_n === 1'b1, "R9 int_n", int_n, 1);
    check(rx_valid === 1'b0, "R9 rx_valid", rx_valid, 0);
    check(miso_oe === 1'b0, "R3 idle oe", miso_oe, 0);
  endtask

  task automatic t_rx_two;
    logic [15:0] d; bit st;
    xfer(16, 16'hA53C, -1, d, st);
    check(rx_valid === 1'b1, "R1 valid", rx_valid, 1);
    check(rx_data === 16'hA53C, "R1 data", rx_data, 16'hA53C);
    check(rx_len === 2'd2, "R1 len", rx_len, 2);
    check(d === 16'h0000, "R2 no flags", d, 0);
    check(st, "R2 miso holds while sclk high", st, 1);
    check(int_n === 1'b1, "R4 no event", int_n, 1);
    accept();
    check(rx_valid === 1'b0, "R8 accepted", rx_valid, 0);
  endtask

  task automatic t_rx_one;
    logic [15:0] d; bit st;
    xfer(8, 16'h005A, -1, d, st);
    check(rx_data === 16'h005A, "R1 one byte data", rx_data, 16'h005A);
    check(rx_len === 2'd1, "R1 one byte len", rx_len, 1);
    accept();
  endtask

  task automatic t_ovf_and_partial;
    logic [15:0] d; bit st;
    pulse_evt(1'b1);
    wclk(1);
    check(int_n === 1'b0, "R4 ovf asserts", int_n, 0);
    xfer(5, 16'h001F, -1, d, st);
    check(rx_valid === 1'b0, "R6 partial no data", rx_valid, 0);
    check(int_n === 1'b0, "R6 partial keeps irq", int_n, 0);
    xfer(24, 16'hFFFF, -1, d, st);
    check(rx_valid === 1'b0, "R6 oversize no data", rx_valid, 0);
    check(int_n === 1'b0, "R6 oversize keeps irq", int_n, 0);
    xfer(8, 16'h00C3, -1, d, st);
    check(d[7:0] === 8'h01, "R2 ovf flag byte", d[7:0], 8'h01);
    check(int_n === 1'b1, "R5 read clears", int_n, 1);
    accept();
  endtask

  task automatic t_mid_frame;
    logic [15:0] d; bit st;
    pulse_evt(1'b1);
    xfer(16, 16'h00C3, 4, d, st);
    check(d === 16'h0001, "R2 snapshot ovf only", d, 16'h0001);
    check(int_n === 1'b0, "R7 mid-frame event kept", int_n, 0);
    accept();
    xfer(8, 16'h00C3, -1, d, st);
    check(d[7:0] === 8'h02, "R7 eom flag byte", d[7:0], 8'h02);
    check(int_n === 1'b1, "R5 cleared", int_n, 1);
    accept();
  endtask

  task automatic t_backpressure;
    logic [15:0] d; bit st;
    xfer(16, 16'h1111, -1, d, st);
    xfer(16, 16'h2222, -1, d, st);
    check(rx_valid === 1'b1, "R8 held valid", rx_valid, 1);
    check(rx_data === 16'h1111, "R8 held data", rx_data, 16'h1111);
    accept();
    check(rx_valid === 1'b0, "R8 second dropped", rx_valid, 0);
    check(miso_oe === 1'b0, "R3 deselected", miso_oe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_rx_two();
    t_rx_one();
    t_ovf_and_partial();
    t_mid_frame();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule